// File: doc/BRIEF.md
# DDR2 Command Spacing Monitor

This block watches a decoded DDR2 command stream, one command per clock, and reports any command that arrives sooner than a minimum spacing allows after an earlier command. It checks four spacing rules. Activates to two different banks need a gap. A read needs a gap after a write to the same bank. A precharge needs a gap after both a write and a read to its bank, and the read gap grows with the additive latency. An activate needs a gap after a write with auto-precharge to the same bank.

All limits are given in picoseconds and converted to clock counts at elaboration, using the clock period and integer ceiling division. The auto-precharge gap is the sum of two counts that are each rounded up on their own: write recovery and precharge. A speed-grade parameter picks the default clock period (3750 ps or 5000 ps) and the write-to-read limit. The monitor never stalls or changes the stream. It only reports, one clock after the offending command.

Top module: `ddr2_spacing_mon`

## Requirements
- R1: Each limit in picoseconds becomes the smallest whole number of clocks that covers it, ceil(ps / period). The auto-precharge limit is ceil(write recovery / period) + ceil(precharge / period). With the fast-grade defaults the counts are: bank-to-bank activate 2, write-to-read 2, write-to-precharge 4, read-to-precharge 2, auto-precharge 8.
- R2: A valid activate (command code 1) to bank B is a violation, code 1, when fewer clocks than the activate-to-activate count have passed since the most recent activate and that activate was to a bank other than B. An activate to the same bank is never flagged by this rule.
- R3: A valid read (code 2) to bank B is a violation, code 2, when fewer clocks than the write-to-read count have passed since the last write (code 3) or auto-precharge write (code 5) to bank B.
- R4: A valid precharge (code 4) to bank B is a violation, code 3, when fewer clocks than the write-to-precharge count have passed since the last plain write to bank B.
- R5: A valid precharge to bank B is a violation, code 4, when fewer than AL + (read-to-precharge count) clocks have passed since the most recent read to bank B. AL is the additive latency sampled with that read.
- R6: A valid activate to bank B is a violation, code 5, when fewer clocks than the auto-precharge count have passed since the last auto-precharge write to bank B.
- R7: When a command breaks two rules at once, the reported code follows a fixed priority. For an activate, code 5 wins over code 1. For a precharge, code 3 wins over code 4.
- R8: Every valid command becomes the new reference point for its rules, even when it was itself a violation.
- R9: After reset no rule is pending. The flag and the code read 0, and the first command after reset is never flagged.
- R10: A cycle with the valid strobe low, or a valid command with code 0, 6 or 7, is never flagged and does not move any reference point.
- R11: The flag and the code appear on the clock edge after the command is sampled and last for one cycle. The code is 0 whenever the flag is low.
- R12: Banks are independent. A write, read or auto-precharge write to one bank never causes a violation on another bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | A command is present this cycle |
| cmd_i | input | 3 | Command code: 0 none, 1 activate, 2 read, 3 write, 4 precharge, 5 write with auto-precharge, 6 refresh, 7 other |
| bank_i | input | BANK_W | Bank addressed by the command |
| al_i | input | AL_W | Additive latency in clocks, used with reads |
| viol_o | output | 1 | A spacing violation was seen on the previous cycle's command |
| viol_code_o | output | 3 | Broken rule: 0 none, 1 bank-to-bank activate, 2 write-to-read, 3 write-to-precharge, 4 read-to-precharge, 5 auto-precharge-to-activate |

## Verification
The bound assertions check on every cycle that a flag only follows a valid command, and that each code follows the kind of command it belongs to. They also check that two back-to-back activates to different banks are always flagged. The exact clock counts, the widening of the read-to-precharge gap with additive latency, the priority between two broken rules, and the rule that a violating command becomes the new reference can only be shown by the bench. Its behavioural model tracks the cycle of every past command and compares the outputs on every clock, through directed boundary cases and a long random stream.

// File: rtl/ddr2_mon_pkg.sv
package ddr2_mon_pkg;

   typedef enum logic [2:0] {
      CMD_NOP  = 3'd0,
      CMD_ACT  = 3'd1,
      CMD_RD   = 3'd2,
      CMD_WR   = 3'd3,
      CMD_PRE  = 3'd4,
      CMD_WRA  = 3'd5,
      CMD_REF  = 3'd6,
      CMD_MISC = 3'd7
   } ddr2_cmd_e;

   typedef enum logic [2:0] {
      VIO_NONE = 3'd0,
      VIO_RRD  = 3'd1,
      VIO_WTR  = 3'd2,
      VIO_WR   = 3'd3,
      VIO_RTP  = 3'd4,
      VIO_DAL  = 3'd5
   } ddr2_vio_e;

   // Smallest clock count that covers a duration in picoseconds.
   function automatic int ps_to_clk(input int dur_ps, input int tck_ps);
      return (dur_ps + tck_ps - 1) / tck_ps;
   endfunction

   // A spacing of n clocks is held by a countdown loaded with n-1.
   function automatic int clk_to_load(input int n);
      return (n > 0) ? n - 1 : 0;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ddr2_span_timer.sv
module ddr2_span_timer #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   output logic         busy_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= load_val_i;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/ddr2_bank_track.sv
module ddr2_bank_track
   import ddr2_mon_pkg::*;
#(
   parameter int W      = 4,
   parameter int AL_W   = 3,
   parameter int LD_WTR = 1,
   parameter int LD_WR  = 3,
   parameter int LD_RTP = 1,
   parameter int LD_DAL = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sel_i,
   input  ddr2_cmd_e       cmd_i,
   input  logic [AL_W-1:0] al_i,
   output logic            wtr_busy_o,
   output logic            wr_busy_o,
   output logic            rtp_busy_o,
   output logic            dal_busy_o
);

   localparam logic [W-1:0] LD_WTR_V = W'(LD_WTR);
   localparam logic [W-1:0] LD_WR_V  = W'(LD_WR);
   localparam logic [W-1:0] LD_RTP_V = W'(LD_RTP);
   localparam logic [W-1:0] LD_DAL_V = W'(LD_DAL);

   logic         is_wr, is_wra, is_rd;
   logic [W-1:0] rtp_load;

   assign is_wr    = sel_i && (cmd_i == CMD_WR);
   assign is_wra   = sel_i && (cmd_i == CMD_WRA);
   assign is_rd    = sel_i && (cmd_i == CMD_RD);
   assign rtp_load = LD_RTP_V + W'(al_i);

   ddr2_span_timer #(.W(W)) u_wtr (
      .clk(clk), .rst_n(rst_n), .load_i(is_wr || is_wra),
      .load_val_i(LD_WTR_V), .busy_o(wtr_busy_o)
   );

   ddr2_span_timer #(.W(W)) u_wr (
      .clk(clk), .rst_n(rst_n), .load_i(is_wr),
      .load_val_i(LD_WR_V), .busy_o(wr_busy_o)
   );

   ddr2_span_timer #(.W(W)) u_rtp (
      .clk(clk), .rst_n(rst_n), .load_i(is_rd),
      .load_val_i(rtp_load), .busy_o(rtp_busy_o)
   );

   ddr2_span_timer #(.W(W)) u_dal (
      .clk(clk), .rst_n(rst_n), .load_i(is_wra),
      .load_val_i(LD_DAL_V), .busy_o(dal_busy_o)
   );

endmodule

// File: rtl/ddr2_spacing_mon.sv
module ddr2_spacing_mon
   import ddr2_mon_pkg::*;
#(
   parameter bit FAST_GRADE   = 1'b1,
   parameter int TCK_PS       = 0,
   parameter int BANK_W       = 2,
   parameter int AL_W         = 3,
   parameter int TRRD_PS      = 7500,
   parameter int TWR_PS       = 15000,
   parameter int TRTP_PS      = 7500,
   parameter int TRP_PS       = 15000,
   parameter int TWTR_FAST_PS = 7500,
   parameter int TWTR_SLOW_PS = 10000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid_i,
   input  logic [2:0]        cmd_i,
   input  logic [BANK_W-1:0] bank_i,
   input  logic [AL_W-1:0]   al_i,
   output logic              viol_o,
   output logic [2:0]        viol_code_o
);

   localparam int NUM_BANKS = 1 << BANK_W;
   localparam int TCK_EFF   = (TCK_PS > 0) ? TCK_PS : (FAST_GRADE ? 3750 : 5000);
   localparam int TWTR_EFF  = FAST_GRADE ? TWTR_FAST_PS : TWTR_SLOW_PS;

   localparam int N_RRD = ps_to_clk(TRRD_PS, TCK_EFF);
   localparam int N_WTR = ps_to_clk(TWTR_EFF, TCK_EFF);
   localparam int N_WR  = ps_to_clk(TWR_PS, TCK_EFF);
   localparam int N_RTP = ps_to_clk(TRTP_PS, TCK_EFF);
   localparam int N_RP  = ps_to_clk(TRP_PS, TCK_EFF);
   localparam int N_DAL = N_WR + N_RP;

   localparam int LD_RRD = clk_to_load(N_RRD);
   localparam int LD_WTR = clk_to_load(N_WTR);
   localparam int LD_WR  = clk_to_load(N_WR);
   localparam int LD_RTP = clk_to_load(N_RTP);
   localparam int LD_DAL = clk_to_load(N_DAL);

   localparam int AL_MAX  = (1 << AL_W) - 1;
   localparam int MAX_FIX = max2(max2(LD_RRD, LD_WTR), max2(max2(LD_WR, LD_RTP), LD_DAL));
   localparam int CNT_W   = $clog2(MAX_FIX + AL_MAX + 2);

   localparam logic [CNT_W-1:0] LD_RRD_V = CNT_W'(LD_RRD);

   // Elaboration-time configuration checks
   if (TCK_EFF <= 0) begin : g_bad_tck
      $error("clock period must be positive");
   end
   if (BANK_W < 1 || BANK_W > 4) begin : g_bad_bank
      $error("BANK_W out of range 1..4");
   end
   if (AL_W < 1 || AL_W > 4) begin : g_bad_al
      $error("AL_W out of range 1..4");
   end
   if (N_RTP < 1 || N_RRD < 1) begin : g_bad_rtp
      $error("read-to-precharge and activate spacings need at least one clock");
   end

   ddr2_cmd_e         cmd;
   logic              act_v;
   logic              rrd_busy;
   logic [BANK_W-1:0] last_act_bank_q;
   logic [NUM_BANKS-1:0] wtr_busy, wr_busy, rtp_busy, dal_busy;
   ddr2_vio_e         vio_d, vio_q;

   assign cmd   = ddr2_cmd_e'(cmd_i);
   assign act_v = cmd_valid_i && (cmd == CMD_ACT);

   // Shared activate-to-activate spacing
   ddr2_span_timer #(.W(CNT_W)) u_rrd (
      .clk(clk), .rst_n(rst_n), .load_i(act_v),
      .load_val_i(LD_RRD_V), .busy_o(rrd_busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         last_act_bank_q <= '0;
      else if (act_v)
         last_act_bank_q <= bank_i;
   end

   // Per-bank write/read/auto-precharge spacings
   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      ddr2_bank_track #(
         .W(CNT_W), .AL_W(AL_W),
         .LD_WTR(LD_WTR), .LD_WR(LD_WR), .LD_RTP(LD_RTP), .LD_DAL(LD_DAL)
      ) u_trk (
         .clk(clk),
         .rst_n(rst_n),
         .sel_i(cmd_valid_i && (bank_i == BANK_W'(g))),
         .cmd_i(cmd),
         .al_i(al_i),
         .wtr_busy_o(wtr_busy[g]),
         .wr_busy_o(wr_busy[g]),
         .rtp_busy_o(rtp_busy[g]),
         .dal_busy_o(dal_busy[g])
      );
   end

   // Rule selection with fixed priority
   always_comb begin
      vio_d = VIO_NONE;
      if (cmd_valid_i) begin
         unique case (cmd)
            CMD_ACT: begin
               if (dal_busy[bank_i])
                  vio_d = VIO_DAL;
               else if (rrd_busy && (bank_i != last_act_bank_q))
                  vio_d = VIO_RRD;
            end
            CMD_RD: begin
               if (wtr_busy[bank_i])
                  vio_d = VIO_WTR;
            end
            CMD_PRE: begin
               if (wr_busy[bank_i])
                  vio_d = VIO_WR;
               else if (rtp_busy[bank_i])
                  vio_d = VIO_RTP;
            end
            default: vio_d = VIO_NONE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         vio_q <= VIO_NONE;
      else
         vio_q <= vio_d;
   end

   assign viol_code_o = vio_q;
   assign viol_o      = (vio_q != VIO_NONE);

endmodule

// File: rtl/ddr2_spacing_mon_chk.sv
module ddr2_spacing_mon_chk
   import ddr2_mon_pkg::*;
#(
   parameter int N_RRD  = 2,
   parameter int BANK_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid_i,
   input logic [2:0]        cmd_i,
   input logic [BANK_W-1:0] bank_i,
   input logic              viol_o,
   input logic [2:0]        viol_code_o
);

   // Two cycles out of reset before any look into the past
   logic arm1_q, arm2_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm1_q <= 1'b0;
         arm2_q <= 1'b0;
      end else begin
         arm1_q <= 1'b1;
         arm2_q <= arm1_q;
      end
   end

   assert_legal_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
      viol_code_o <= 3'd5);

   assert_flag_needs_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (arm1_q && viol_o) |-> $past(cmd_valid_i));

   assert_rrd_on_act_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (arm1_q && viol_code_o == 3'd1) |-> $past(cmd_i) == 3'd1);

   assert_wtr_on_rd_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (arm1_q && viol_code_o == 3'd2) |-> $past(cmd_i) == 3'd2);

   assert_pre_codes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (arm1_q && (viol_code_o == 3'd3 || viol_code_o == 3'd4)) |-> $past(cmd_i) == 3'd4);

   assert_dal_on_act_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (arm1_q && viol_code_o == 3'd5) |-> $past(cmd_i) == 3'd1);

   if (N_RRD > 1) begin : g_b2b
      assert_b2b_act_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (arm2_q && cmd_valid_i && cmd_i == 3'd1 &&
          $past(cmd_valid_i) && $past(cmd_i) == 3'd1 && bank_i != $past(bank_i))
         |=> viol_o);
   end

endmodule

bind ddr2_spacing_mon ddr2_spacing_mon_chk #(
   .N_RRD(N_RRD), .BANK_W(BANK_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_i(cmd_i),
   .bank_i(bank_i), .viol_o(viol_o), .viol_code_o(viol_code_o)
);

// File: tb/tb_ddr2_spacing_mon.sv
module tb_ddr2_spacing_mon;

   localparam int CLK_PERIOD = 10;
   localparam int TCK = 3750;
   // Expected clock counts, worked from the picosecond limits
   localparam int E_RRD = (7500 + TCK - 1) / TCK;
   localparam int E_WTR = (7500 + TCK - 1) / TCK;
   localparam int E_WR  = (15000 + TCK - 1) / TCK;
   localparam int E_RTP = (7500 + TCK - 1) / TCK;
   localparam int E_DAL = E_WR + (15000 + TCK - 1) / TCK;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid_i = 1'b0;
   logic [2:0] cmd_i = 3'd0;
   logic [1:0] bank_i = 2'd0;
   logic [2:0] al_i = 3'd0;
   logic       viol_o;
   logic [2:0] viol_code_o;

   ddr2_spacing_mon dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_i(cmd_i),
      .bank_i(bank_i), .al_i(al_i), .viol_o(viol_o), .viol_code_o(viol_code_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   int exp_code = 0;
   string exp_tag = "R9";

   // Behavioural reference: cycle numbers of past commands
   int last_act = -1000;
   int last_act_bank = 0;
   int last_wtr[4];
   int last_wr[4];
   int last_rd[4];
   int rd_al[4];
   int last_wra[4];

   task automatic compare();
      checks++;
      if (viol_o !== (exp_code != 0) || viol_code_o !== exp_code[2:0]) begin
         fails++;
         $display("FAIL %s: flag=%0b code=%0d expected flag=%0b code=%0d at cycle %0d",
                  exp_tag, viol_o, viol_code_o, exp_code != 0, exp_code, cyc);
      end
   endtask

   task automatic step(input bit v, input int c, input int b, input int al, input string tag);
      int code;
      @(negedge clk);
      compare();
      cmd_valid_i = v;
      cmd_i  = c[2:0];
      bank_i = b[1:0];
      al_i   = al[2:0];
      code = 0;
      if (v) begin
         case (c)
            1: begin
               if (cyc - last_wra[b] < E_DAL) code = 5;
               else if (b != last_act_bank && cyc - last_act < E_RRD) code = 1;
               last_act = cyc;
               last_act_bank = b;
            end
            2: begin
               if (cyc - last_wtr[b] < E_WTR) code = 2;
               last_rd[b] = cyc;
               rd_al[b] = al;
            end
            3: begin
               last_wtr[b] = cyc;
               last_wr[b] = cyc;
            end
            4: begin
               if (cyc - last_wr[b] < E_WR) code = 3;
               else if (cyc - last_rd[b] < rd_al[b] + E_RTP) code = 4;
            end
            5: begin
               last_wtr[b] = cyc;
               last_wra[b] = cyc;
            end
            default: ;
         endcase
      end
      exp_code = code;
      exp_tag = tag;
      cyc++;
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(1'b0, 0, 0, 0, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4; i++) begin
         last_wtr[i] = -1000; last_wr[i] = -1000; last_rd[i] = -1000;
         rd_al[i] = 0; last_wra[i] = -1000;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R9: reset state, then a precharge right away is not flagged
      step(1'b1, 4, 0, 0, "R9");
      step(1'b1, 2, 1, 0, "R9");
      idle(2, "R9");

      // R2: activates to different banks, R8: violator becomes reference
      step(1'b1, 1, 0, 0, "R2");
      step(1'b1, 1, 1, 0, "R2");
      step(1'b1, 1, 2, 0, "R8");
      step(1'b0, 0, 0, 0, "R2");
      step(1'b1, 1, 3, 0, "R1");
      step(1'b1, 1, 3, 0, "R2");
      idle(3, "R2");

      // R3 and R12
      step(1'b1, 3, 1, 0, "R3");
      step(1'b1, 2, 1, 0, "R3");
      step(1'b1, 3, 1, 0, "R3");
      step(1'b1, 2, 2, 0, "R12");
      step(1'b1, 2, 1, 0, "R1");
      idle(3, "R3");

      // R4 boundary
      step(1'b1, 3, 2, 0, "R4");
      step(1'b1, 4, 2, 0, "R4");
      step(1'b1, 4, 3, 0, "R12");
      idle(1, "R4");
      step(1'b1, 4, 2, 0, "R1");
      idle(3, "R4");

      // R5 with AL=2 and AL=0
      step(1'b1, 2, 3, 2, "R5");
      idle(2, "R5");
      step(1'b1, 4, 3, 0, "R5");
      step(1'b1, 4, 3, 0, "R5");
      step(1'b1, 2, 3, 0, "R5");
      step(1'b1, 4, 3, 0, "R5");
      step(1'b1, 4, 3, 0, "R5");
      idle(3, "R5");

      // R6 boundary
      step(1'b1, 5, 0, 0, "R6");
      idle(5, "R6");
      step(1'b1, 1, 0, 0, "R6");
      step(1'b1, 1, 0, 0, "R1");
      idle(9, "R6");

      // R7 priority on activate and on precharge
      step(1'b1, 5, 0, 0, "R7");
      idle(4, "R7");
      step(1'b1, 1, 1, 0, "R7");
      step(1'b1, 1, 0, 0, "R7");
      idle(9, "R7");
      step(1'b1, 3, 2, 0, "R7");
      step(1'b1, 2, 2, 0, "R7");
      step(1'b1, 4, 2, 0, "R7");
      idle(5, "R7");

      // R10: strobe low or other codes neither flag nor move references
      step(1'b1, 1, 0, 0, "R10");
      step(1'b0, 1, 1, 0, "R10");
      step(1'b1, 6, 1, 0, "R10");
      step(1'b1, 7, 2, 0, "R10");
      step(1'b1, 0, 3, 0, "R10");
      step(1'b1, 1, 1, 0, "R10");
      idle(2, "R11");

      // Random stream against the model
      for (int i = 0; i < 4000; i++) begin
         step($urandom_range(0, 3) != 0, int'($urandom_range(0, 7)),
              int'($urandom_range(0, 3)), int'($urandom_range(0, 7)), "R12");
      end
      idle(2, "R11");

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule